// File: doc/BRIEF.md
# Configurable Interrupt Controller with Edge Latches

This block gathers up to 32 external interrupt lines and drives two request outputs and a wake output. Each source has its own trigger mode. The modes are rising edge, falling edge, both edges, active-high level and active-low level, and a source can also be switched off. Each raw line passes through a two-flop synchroniser. A rising edge and a falling edge are held in two separate latch registers, and each latched bit stays set until software clears it.

Software reaches the block through a simple register port. The port has an address, a write strobe and a data word, and read data comes back one cycle after the address is presented. Every per-source setting has a read address, a write-one-to-set address and a write-one-to-clear address. With these, one source can be changed without a read-modify-write. A routing bit sends each enabled source to request 0 or request 1. One readable pending register per request shows which sources are driving that request. A separate wake-enable register lets selected sources assert the wake output even while they are masked.

Top module: `irqc_top`

## Requirements
- R1: The trigger mode of source n is {mode2[n], mode1[n], mode0[n]}. The codes are: 001 rising edge, 010 falling edge, 011 either edge, 101 high level, 110 low level. Code 000, and the unused codes 100 and 111, make the source inactive. An edge that the current mode does not select is not latched.
- R2: Register k (0 mode0, 1 mode1, 2 mode2, 3 route, 4 source-select, 5 enable, 6 wake-enable) is read at address 4k. Writing to address 4k+1 sets every bit where the write data is 1. Writing to address 4k+2 clears every bit where the write data is 1. Bits where the write data is 0 keep their value.
- R3: A source whose route bit is 1 drives req0. A source whose route bit is 0 drives req1.
- R4: A synchronised rising edge of a source in mode 001 or 011 sets its bit in the rise latch, which is read at address 28. A falling edge of a source in mode 010 or 011 sets its bit in the fall latch, which is read at address 32. A latched bit stays set until a 1 is written to that bit position at address 30 (rise) or address 34 (fall).
- R5: A source contributes to a request only while its enable bit is 1. Clearing the enable bit removes the request but keeps any latched edge. Setting the enable bit again restores the request.
- R6: Pending register 0 is read at address 36 and pending register 1 at address 40. Each holds the active, enabled sources routed to its request. req0 and req1 are the OR of their pending registers.
- R7: wake is high while any active source has its wake-enable bit set, whatever its enable bit.
- R8: A test register at address 44 is written and read at that address. It reads 0 after reset.
- R9: After reset the mode, enable and wake-enable registers are 0. The route and source-select registers are all ones. Both latches and the test register are 0. req0, req1 and wake are low.
- R10: A level-mode source is not latched. It is active while its synchronised input is 1 (mode 101) or 0 (mode 110).
- R11: Read data for the address presented in one cycle is valid in the next cycle. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| irq_in | input | 32 | Raw interrupt lines, asynchronous |
| req0 | output | 1 | Request output 0 |
| req1 | output | 1 | Request output 1 |
| wake | output | 1 | Wake output |

## Verification
A wrong mode decode or a missed edge capture shows up on req0 within three clocks of the input change, and it shows up one clock later in the pending readback. A latch that clears by itself, or a clear that does not take effect, changes the latch readback on the very next read. A routing or masking fault moves the request to the wrong output, or leaves it asserted, in the cycle after the register write. A wake-gating fault shows on wake without any register access.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [2:0] {
        TRIG_OFF  = 3'b000,
        TRIG_RISE = 3'b001,
        TRIG_FALL = 3'b010,
        TRIG_BOTH = 3'b011,
        TRIG_HIGH = 3'b101,
        TRIG_LOW  = 3'b110
    } trig_mode_e;

    typedef enum logic [1:0] {
        OP_READ = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_RSVD = 2'd3
    } reg_op_e;

    typedef struct packed {
        logic cap_rise;
        logic cap_fall;
        logic use_level;
        logic invert;
    } trig_ctl_t;

    localparam int NUM_RW    = 7;
    localparam int IDX_MODE0 = 0;
    localparam int IDX_MODE1 = 1;
    localparam int IDX_MODE2 = 2;
    localparam int IDX_ROUTE = 3;
    localparam int IDX_SRC   = 4;
    localparam int IDX_EN    = 5;
    localparam int IDX_WAKE  = 6;

    localparam int A_RISE_RD  = 28;
    localparam int A_RISE_CLR = 30;
    localparam int A_FALL_RD  = 32;
    localparam int A_FALL_CLR = 34;
    localparam int A_PEND0    = 36;
    localparam int A_PEND1    = 40;
    localparam int A_TEST     = 44;

    function automatic trig_ctl_t decode_trig(logic [2:0] code);
        trig_ctl_t c;
        c = '0;
        case (code)
            TRIG_RISE: c.cap_rise = 1'b1;
            TRIG_FALL: c.cap_fall = 1'b1;
            TRIG_BOTH: begin c.cap_rise = 1'b1; c.cap_fall = 1'b1; end
            TRIG_HIGH: c.use_level = 1'b1;
            TRIG_LOW:  begin c.use_level = 1'b1; c.invert = 1'b1; end
            default:   c = '0;
        endcase
        return c;
    endfunction

    function automatic bit rw_resets_high(int idx);
        return (idx == IDX_ROUTE) || (idx == IDX_SRC);
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [NSRC-1:0]   wdata,
    output logic [NSRC-1:0]   rw_q [NUM_RW],
    output logic [NSRC-1:0]   test_q,
    output logic [NSRC-1:0]   rise_clr,
    output logic [NSRC-1:0]   fall_clr
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    reg_op_e          op;

    assign idx = addr[ADDR_W-1:2];
    assign op  = reg_op_e'(addr[1:0]);

    for (genvar k = 0; k < NUM_RW; k++) begin : g_rw
        localparam logic [NSRC-1:0] RST_VAL = rw_resets_high(k) ? '1 : '0;
        always_ff @(posedge clk) begin
            if (rst) begin
                rw_q[k] <= RST_VAL;
            end else if (we && idx == IDX_W'(k)) begin
                if (op == OP_SET)      rw_q[k] <= rw_q[k] | wdata;
                else if (op == OP_CLR) rw_q[k] <= rw_q[k] & ~wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                test_q <= '0;
        else if (we && addr == ADDR_W'(A_TEST)) test_q <= wdata;
    end

    assign rise_clr = (we && addr == ADDR_W'(A_RISE_CLR)) ? wdata : '0;
    assign fall_clr = (we && addr == ADDR_W'(A_FALL_CLR)) ? wdata : '0;

    // R2
    en_set_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == ADDR_W'(4*IDX_EN + 1)) |=>
        ((rw_q[IDX_EN] & $past(wdata)) == $past(wdata)));

    // R2
    en_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == ADDR_W'(4*IDX_EN + 2)) |=>
        ((rw_q[IDX_EN] & $past(wdata)) == '0));

    // R9
    reset_val_chk: assert property (@(posedge clk)
        rst |=> (rw_q[IDX_EN] == '0 && rw_q[IDX_ROUTE] == '1 &&
                 rw_q[IDX_MODE0] == '0 && test_q == '0));
endmodule

// File: rtl/irqc_trigger.sv
module irqc_trigger
    import irqc_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] lvl,
    input  logic [NSRC-1:0] mode0,
    input  logic [NSRC-1:0] mode1,
    input  logic [NSRC-1:0] mode2,
    input  logic [NSRC-1:0] rise_clr,
    input  logic [NSRC-1:0] fall_clr,
    output logic [NSRC-1:0] rise_q,
    output logic [NSRC-1:0] fall_q,
    output logic [NSRC-1:0] active
);
    logic [NSRC-1:0] prev_q;
    logic [NSRC-1:0] rise_evt;
    logic [NSRC-1:0] fall_evt;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    for (genvar n = 0; n < NSRC; n++) begin : g_src
        trig_ctl_t ctl;
        assign ctl         = decode_trig({mode2[n], mode1[n], mode0[n]});
        assign rise_evt[n] = ctl.cap_rise & lvl[n] & ~prev_q[n];
        assign fall_evt[n] = ctl.cap_fall & ~lvl[n] & prev_q[n];

        always_ff @(posedge clk) begin
            if (rst) begin
                rise_q[n] <= 1'b0;
                fall_q[n] <= 1'b0;
            end else begin
                rise_q[n] <= (rise_q[n] & ~rise_clr[n]) | rise_evt[n];
                fall_q[n] <= (fall_q[n] & ~fall_clr[n]) | fall_evt[n];
            end
        end

        assign active[n] = ctl.use_level ? (lvl[n] ^ ctl.invert)
                         : ((ctl.cap_rise & rise_q[n]) | (ctl.cap_fall & fall_q[n]));
    end

    // R4
    rise_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((rise_q & $past(rise_q & ~rise_clr)) == $past(rise_q & ~rise_clr)));

    // R4
    rise_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (|(rise_clr & ~rise_evt)) |=> ((rise_q & $past(rise_clr & ~rise_evt)) == '0));

    // R4
    fall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((fall_q & $past(fall_q & ~fall_clr)) == $past(fall_q & ~fall_clr)));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NSRC-1:0]   bus_wdata,
    output logic [NSRC-1:0]   bus_rdata,
    input  logic [NSRC-1:0]   irq_in,
    output logic              req0,
    output logic              req1,
    output logic              wake
);
    localparam int IDX_W = ADDR_W - 2;

    logic [NSRC-1:0] lvl;
    logic [NSRC-1:0] rw_q [NUM_RW];
    logic [NSRC-1:0] test_q;
    logic [NSRC-1:0] rise_clr, fall_clr;
    logic [NSRC-1:0] rise_q, fall_q, active;
    logic [NSRC-1:0] gated, pend0, pend1;
    logic [NSRC-1:0] rd_mux;

    irqc_sync #(.W(NSRC)) u_sync (
        .clk (clk), .rst (rst), .d (irq_in), .q (lvl)
    );

    irqc_regs #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_regs (
        .clk (clk), .rst (rst), .addr (bus_addr), .we (bus_we),
        .wdata (bus_wdata), .rw_q (rw_q), .test_q (test_q),
        .rise_clr (rise_clr), .fall_clr (fall_clr)
    );

    irqc_trigger #(.NSRC(NSRC)) u_trig (
        .clk (clk), .rst (rst), .lvl (lvl),
        .mode0 (rw_q[IDX_MODE0]), .mode1 (rw_q[IDX_MODE1]), .mode2 (rw_q[IDX_MODE2]),
        .rise_clr (rise_clr), .fall_clr (fall_clr),
        .rise_q (rise_q), .fall_q (fall_q), .active (active)
    );

    assign gated = active & rw_q[IDX_EN];
    assign pend0 = gated & rw_q[IDX_ROUTE];
    assign pend1 = gated & ~rw_q[IDX_ROUTE];
    assign req0  = |pend0;
    assign req1  = |pend1;
    assign wake  = |(active & rw_q[IDX_WAKE]);

    always_comb begin
        rd_mux = '0;
        if (bus_addr[1:0] == OP_READ) begin
            for (int k = 0; k < NUM_RW; k++)
                if (bus_addr[ADDR_W-1:2] == IDX_W'(k)) rd_mux = rw_q[k];
        end
        case (bus_addr)
            ADDR_W'(A_RISE_RD): rd_mux = rise_q;
            ADDR_W'(A_FALL_RD): rd_mux = fall_q;
            ADDR_W'(A_PEND0):   rd_mux = pend0;
            ADDR_W'(A_PEND1):   rd_mux = pend1;
            ADDR_W'(A_TEST):    rd_mux = test_q;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= rd_mux;
    end

    // R5
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADDR_W'(4*IDX_EN + 2) && bus_wdata == '1) |=> !(req0 || req1));
endmodule

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;
    localparam int CLK_PERIOD = 10;

    localparam logic [5:0] A_MODE0 = 6'd0, A_MODE1 = 6'd4, A_MODE2 = 6'd8;
    localparam logic [5:0] A_ROUTE = 6'd12, A_SRCS = 6'd16, A_EN = 6'd20, A_WAKE = 6'd24;
    localparam logic [5:0] A_RISE = 6'd28, A_RISEC = 6'd30, A_FALL = 6'd32, A_FALLC = 6'd34;
    localparam logic [5:0] A_P0 = 6'd36, A_P1 = 6'd40, A_TST = 6'd44;

    typedef struct packed {
        logic [2:0] mode;
        logic       lv0;
        logic       lv1;
        logic       exp;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{3'b001, 1'b0, 1'b1, 1'b1}, '{3'b001, 1'b1, 1'b0, 1'b0},
        '{3'b010, 1'b1, 1'b0, 1'b1}, '{3'b010, 1'b0, 1'b1, 1'b0},
        '{3'b011, 1'b0, 1'b1, 1'b1}, '{3'b011, 1'b1, 1'b0, 1'b1},
        '{3'b101, 1'b0, 1'b1, 1'b1}, '{3'b101, 1'b1, 1'b0, 1'b0},
        '{3'b110, 1'b1, 1'b0, 1'b1}, '{3'b110, 1'b0, 1'b1, 1'b0},
        '{3'b000, 1'b0, 1'b1, 1'b0}, '{3'b111, 1'b0, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_in = '0;
    logic        req0, req1, wake;

    int checks = 0;
    int fails  = 0;
    logic [31:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqc_top dut_i (
        .clk (clk), .rst (rst), .bus_addr (bus_addr), .bus_we (bus_we),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .irq_in (irq_in),
        .req0 (req0), .req1 (req1), .wake (wake)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rdreg(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        // R9 reset values
        chk("R9 req0", {31'b0, req0}, 32'd0);
        chk("R9 req1", {31'b0, req1}, 32'd0);
        chk("R9 wake", {31'b0, wake}, 32'd0);
        rdreg(A_MODE0, rd); chk("R9 mode0", rd, 32'h0);
        rdreg(A_MODE2, rd); chk("R9 mode2", rd, 32'h0);
        rdreg(A_EN, rd);    chk("R9 enable", rd, 32'h0);
        rdreg(A_ROUTE, rd); chk("R9 route", rd, 32'hFFFF_FFFF);
        rdreg(A_SRCS, rd);  chk("R9 srcsel", rd, 32'hFFFF_FFFF);
        rdreg(A_WAKE, rd);  chk("R9 wake-en", rd, 32'h0);
        rdreg(A_RISE, rd);  chk("R9 rise latch", rd, 32'h0);
        rdreg(A_FALL, rd);  chk("R9 fall latch", rd, 32'h0);
        rdreg(A_TST, rd);   chk("R8 test reset", rd, 32'h0);
        rdreg(6'd63, rd);   chk("R11 unmapped", rd, 32'h0);

        // R1 R10 R6 mode table
        foreach (VECS[v]) begin
            int n;
            n = (v * 5 + 2) % 32;
            wr(A_MODE0 + 6'd2, 32'hFFFF_FFFF);
            wr(A_MODE1 + 6'd2, 32'hFFFF_FFFF);
            wr(A_MODE2 + 6'd2, 32'hFFFF_FFFF);
            wr(A_EN + 6'd2, 32'hFFFF_FFFF);
            irq_in[n] = VECS[v].lv0;
            idle(5);
            if (VECS[v].mode[0]) wr(A_MODE0 + 6'd1, 32'd1 << n);
            if (VECS[v].mode[1]) wr(A_MODE1 + 6'd1, 32'd1 << n);
            if (VECS[v].mode[2]) wr(A_MODE2 + 6'd1, 32'd1 << n);
            wr(A_ROUTE + 6'd1, 32'd1 << n);
            wr(A_EN + 6'd1, 32'd1 << n);
            wr(A_RISEC, 32'hFFFF_FFFF);
            wr(A_FALLC, 32'hFFFF_FFFF);
            irq_in[n] = VECS[v].lv1;
            idle(5);
            chk($sformatf("R1 R10 req0 vec %0d", v), {31'b0, req0}, {31'b0, VECS[v].exp});
            chk($sformatf("R3 req1 vec %0d", v), {31'b0, req1}, 32'd0);
            rdreg(A_P0, rd);
            chk($sformatf("R6 pend0 vec %0d", v), rd, VECS[v].exp ? (32'd1 << n) : 32'd0);
        end

        // R2 set/clear semantics
        wr(A_EN + 6'd2, 32'hFFFF_FFFF);
        wr(A_WAKE + 6'd1, 32'h0000_00F0);
        wr(A_WAKE + 6'd1, 32'h0000_0001);
        rdreg(A_WAKE, rd); chk("R2 set accumulates", rd, 32'h0000_00F1);
        wr(A_WAKE + 6'd2, 32'h0000_0010);
        rdreg(A_WAKE, rd); chk("R2 clear one bit", rd, 32'h0000_00E1);
        wr(A_WAKE + 6'd1, 32'h0);
        wr(A_WAKE + 6'd2, 32'h0);
        rdreg(A_WAKE, rd); chk("R2 zero writes no effect", rd, 32'h0000_00E1);
        wr(A_WAKE + 6'd2, 32'hFFFF_FFFF);

        // R5 / R3 / R4 on source 30, rising edge mode
        irq_in = '0;
        wr(A_MODE0 + 6'd2, 32'hFFFF_FFFF);
        wr(A_MODE1 + 6'd2, 32'hFFFF_FFFF);
        wr(A_MODE2 + 6'd2, 32'hFFFF_FFFF);
        idle(4);
        wr(A_RISEC, 32'hFFFF_FFFF);
        wr(A_FALLC, 32'hFFFF_FFFF);
        wr(A_MODE0 + 6'd1, 32'h4000_0000);
        wr(A_ROUTE + 6'd1, 32'h4000_0000);
        wr(A_EN + 6'd1, 32'h4000_0000);
        irq_in[30] = 1'b1;
        idle(5);
        chk("R4 rising edge requests", {31'b0, req0}, 32'd1);
        wr(A_EN + 6'd2, 32'h4000_0000);
        idle(1);
        chk("R5 masked no request", {30'b0, req1, req0}, 32'd0);
        rdreg(A_RISE, rd); chk("R5 latch kept while masked", rd, 32'h4000_0000);
        wr(A_EN + 6'd1, 32'h4000_0000);
        idle(1);
        chk("R5 unmask restores", {31'b0, req0}, 32'd1);
        wr(A_ROUTE + 6'd2, 32'h4000_0000);
        idle(1);
        chk("R3 route 0 to req1", {30'b0, req1, req0}, 32'd2);
        rdreg(A_P1, rd); chk("R6 pend1", rd, 32'h4000_0000);
        rdreg(A_P0, rd); chk("R6 pend0 empty", rd, 32'h0);
        irq_in[30] = 1'b0;
        idle(5);
        rdreg(A_FALL, rd); chk("R1 fall not latched in rise mode", rd, 32'h0);
        chk("R4 latch holds after input drops", {31'b0, req1}, 32'd1);
        wr(A_RISEC, 32'h4000_0000);
        rdreg(A_RISE, rd); chk("R4 rise latch cleared", rd, 32'h0);
        chk("R4 request gone after clear", {31'b0, req1}, 32'd0);

        // R7 wake on masked high-level source 31
        wr(A_MODE0 + 6'd1, 32'h8000_0000);
        wr(A_MODE2 + 6'd1, 32'h8000_0000);
        wr(A_EN + 6'd2, 32'h8000_0000);
        wr(A_WAKE + 6'd1, 32'h8000_0000);
        irq_in[31] = 1'b1;
        idle(4);
        chk("R7 wake while masked", {31'b0, wake}, 32'd1);
        chk("R7 no request while masked", {30'b0, req1, req0}, 32'd0);
        wr(A_WAKE + 6'd2, 32'h8000_0000);
        idle(1);
        chk("R7 wake disabled", {31'b0, wake}, 32'd0);

        // R8 test register
        wr(A_TST, 32'h0000_005A);
        rdreg(A_TST, rd); chk("R8 test readback", rd, 32'h0000_005A);
        wr(A_TST, 32'h0);
        rdreg(A_TST, rd); chk("R8 test zero", rd, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule